// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up-counter built from identical 4-bit stages. All stage registers update together on the rising clock edge. Each stage can be preset synchronously from a parallel data word. An active-low asynchronous clear forces the whole count to zero at once, without waiting for a clock edge.

There are two count enables. The counter advances only when both enables are high. The "t" enable does one more job: it also qualifies each stage's terminal-carry signal. Because of this, the top module chains its stages with no extra gating. Stage k takes its "t" enable from the carry of stage k-1. The first stage takes the external "t" enable. The last stage's carry becomes the block's carry output, so a wider counter can be built by chaining further blocks in the same way.

Load overrides both enables, and clear overrides load, the enables and the clock.

Top module: `cnt_chain`

## Requirements
- R1: The count register `q_o` changes only on a rising edge of `clk_i`, and all of its bits update in the same edge.
- R2: While `rst_ni` is low, `q_o` is 0 and `carry_o` is 0 at once, without a clock edge. This holds whatever the levels of `load_ni`, `data_i`, `en_p_i` and `en_t_i`.
- R3: When `load_ni` is low at a rising edge, `q_o` takes `data_i` on that edge. The levels of `en_p_i` and `en_t_i` make no difference.
- R4: When `load_ni` is high at a rising edge, `q_o` increases by one only if `en_p_i` and `en_t_i` are both high. Otherwise `q_o` keeps its value.
- R5: Counting from the all-ones value gives 0. A single stage wraps from 15 to 0, and the full width wraps from 2^W-1 to 0.
- R6: `carry_o` is combinational. It is high exactly when `q_o` is all ones and `en_t_i` is high, and `en_p_i` has no influence on it.
- R7: Changes on `load_ni`, `data_i`, `en_p_i` or `en_t_i` between clock edges leave `q_o` unchanged. Only the levels present at the rising edge decide the next value.
- R8: The counter follows this sequence, read on the low stage `q_o[3:0]`:
  1. Clear to 0.
  2. Load 12.
  3. Count through 13, 14, 15, 0, 1 and 2.
  4. Hold while `en_p_i` is low.
- R9: Stage k (bits `4k+3:4k`) advances on a counting edge only when every lower stage reads 15. The whole chain therefore behaves as one binary counter of width W = 4*N_STAGES.
- R10: With N_STAGES above 1, a low stage reading 15 alone does not raise `carry_o`. Every stage must read 15.

Parameters: N_STAGES (default 2) and STAGE_W (default 4). W = N_STAGES*STAGE_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel preset, active low |
| data_i | input | W | Preset value |
| en_p_i | input | 1 | Count enable that only gates counting |
| en_t_i | input | 1 | Count enable that also qualifies the carry |
| q_o | output | W | Current count |
| carry_o | output | 1 | Terminal carry: count is all ones and en_t_i is high |

## Verification
The clocked properties assume that the control inputs and the preset word are steady around each rising edge. They also assume that clear is released away from an edge, so that each edge sees one well-defined set of levels.

The bench makes all of its input changes on falling edges, or in the middle of the low or high phase. The "between edges" disturbances are removed again before the next rising edge. Clear is asserted and released in the middle of a phase.

Under these conditions the bench's reference model and the properties both see the same sampled levels. Carry is checked immediately after enable changes, because it does not wait for an edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned STAGE_W_DEF = 4;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } stage_op_e;
endpackage

// File: rtl/cnt_stage_next.sv
module cnt_stage_next
  import cnt_pkg::*;
#(
  parameter int unsigned STAGE_W = STAGE_W_DEF
) (
  input  logic [STAGE_W-1:0] q_i,
  input  logic [STAGE_W-1:0] data_i,
  input  logic               load_ni,
  input  logic               en_p_i,
  input  logic               en_t_i,
  output logic [STAGE_W-1:0] nxt_o
);
  stage_op_e op;

  // load wins over both enables
  always_comb begin
    if (!load_ni)                op = OP_LOAD;
    else if (en_p_i && en_t_i)   op = OP_INC;
    else                         op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: nxt_o = data_i;
      OP_INC:  nxt_o = q_i + STAGE_W'(1);
      default: nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned STAGE_W = STAGE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [STAGE_W-1:0] data_i,
  input  logic               en_p_i,
  input  logic               en_t_i,
  output logic [STAGE_W-1:0] q_o,
  output logic               carry_o
);
  logic [STAGE_W-1:0] q_q, q_d;

  cnt_stage_next #(.STAGE_W(STAGE_W)) u_next (
    .q_i     (q_q),
    .data_i  (data_i),
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .nxt_o   (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o     = q_q;
  // terminal carry, gated by en_t only
  assign carry_o = (&q_q) & en_t_i;
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned STAGE_W  = STAGE_W_DEF,
  localparam int unsigned W       = N_STAGES * STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         en_p_i,
  input  logic         en_t_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  // ent[k] feeds stage k; ent[k+1] is stage k's carry
  logic [N_STAGES:0] ent;

  assign ent[0] = en_t_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_ni (load_ni),
      .data_i  (data_i[k*STAGE_W +: STAGE_W]),
      .en_p_i  (en_p_i),
      .en_t_i  (ent[k]),
      .q_o     (q_o[k*STAGE_W +: STAGE_W]),
      .carry_o (ent[k+1])
    );
  end

  assign carry_o = ent[N_STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned STAGE_W  = 4,
  localparam int unsigned W       = N_STAGES * STAGE_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_ni,
  input logic [W-1:0] data_i,
  input logic         en_p_i,
  input logic         en_t_i,
  input logic [W-1:0] q_o,
  input logic         carry_o
);
  // R2
  clear_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0 && !carry_o));

  // R3
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(data_i));

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_p_i && en_t_i) |=> q_o == W'($past(q_o) + W'(1)));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_p_i && en_t_i)) |=> $stable(q_o));

  // R6
  carry_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == ((&q_o) && en_t_i));

  if (N_STAGES > 1) begin : g_multi
    // R9
    upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_ni && en_p_i && en_t_i && !(&q_o[STAGE_W-1:0]))
        |=> q_o[W-1:STAGE_W] == $past(q_o[W-1:STAGE_W]));
  end
endmodule

bind cnt_chain cnt_chain_chk #(.N_STAGES(N_STAGES), .STAGE_W(STAGE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_ni (load_ni),
  .data_i  (data_i),
  .en_p_i  (en_p_i),
  .en_t_i  (en_t_i),
  .q_o     (q_o),
  .carry_o (carry_o)
);

// File: tb/cnt_chain_test.sv
`timescale 1ns/1ps
module cnt_chain_test;
  localparam int unsigned NS = 2;
  localparam int unsigned SW = 4;
  localparam int unsigned W  = NS * SW;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         en_p_i = 1'b0;
  logic         en_t_i = 1'b0;
  logic [W-1:0] q_o;
  logic         carry_o;

  logic [W-1:0] exp_q = '0;
  int checks = 0;
  int fails  = 0;

  cnt_chain #(.N_STAGES(NS), .STAGE_W(SW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .data_i(data_i),
    .en_p_i(en_p_i), .en_t_i(en_t_i), .q_o(q_o), .carry_o(carry_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " q"}, q_o, exp_q);
    chk({req, " carry"}, W'(carry_o), W'(rst_ni && (&exp_q) && en_t_i));
  endtask

  task automatic drive(input logic ld_n, input logic [W-1:0] d, input logic p, input logic t);
    @(negedge clk_i);
    load_ni = ld_n; data_i = d; en_p_i = p; en_t_i = t;
  endtask

  // advance one rising edge, update the model, check
  task automatic tick(input string req);
    @(posedge clk_i);
    if (!rst_ni)          exp_q = '0;
    else if (!load_ni)    exp_q = data_i;
    else if (en_p_i && en_t_i) exp_q = exp_q + W'(1);
    #3;
    chk_all(req);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; load_ni = 1'b0; data_i = 8'hA5; en_p_i = 1'b1; en_t_i = 1'b1;
    #1; exp_q = '0;
    chk_all("R2 reset");
    tick("R2 reset held over edge");
    @(negedge clk_i); #5 rst_ni = 1'b1;
    load_ni = 1'b1; en_p_i = 1'b0; en_t_i = 1'b0;
  endtask

  task automatic t_sequence;
    drive(1'b0, 8'h0C, 1'b0, 1'b0);
    tick("R8 load 12");
    chk("R8 low nibble 12", W'(q_o[3:0]), W'(12));
    drive(1'b1, 8'h00, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      tick("R8 count");
      chk("R8 low nibble", W'(q_o[3:0]), W'((13 + i) % 16));
    end
    drive(1'b1, 8'h00, 1'b0, 1'b1);
    tick("R8 inhibit");
    tick("R8 inhibit");
    chk("R8 held at 2", W'(q_o[3:0]), W'(2));
  endtask

  task automatic t_load_collide;
    drive(1'b0, 8'h3C, 1'b1, 1'b1);
    tick("R3 load with both enables");
    drive(1'b0, 8'hFF, 1'b1, 1'b0);
    tick("R3 load with en_t low");
    drive(1'b0, 8'h00, 1'b0, 1'b1);
    tick("R3 load with en_p low");
    chk("R3 loaded zero", q_o, 8'h00);
  endtask

  task automatic t_enables;
    drive(1'b0, 8'h41, 1'b0, 1'b0);
    tick("R4 preset");
    drive(1'b1, 8'h00, 1'b0, 1'b1);
    tick("R4 en_p low holds");
    drive(1'b1, 8'h00, 1'b1, 1'b0);
    tick("R4 en_t low holds");
    drive(1'b1, 8'h00, 1'b1, 1'b1);
    tick("R4 both high counts");
    chk("R4 value", q_o, 8'h42);
  endtask

  task automatic t_carry;
    drive(1'b0, 8'hFF, 1'b0, 1'b1);
    tick("R6 load all ones");
    chk("R6 carry high", W'(carry_o), W'(1));
    #2 en_p_i = 1'b1; #1;
    chk("R6 en_p no effect", W'(carry_o), W'(1));
    en_t_i = 1'b0; #1;
    chk("R6 carry follows en_t", W'(carry_o), W'(0));
    drive(1'b0, 8'h0F, 1'b0, 1'b1);
    tick("R10 low stage only");
    chk("R10 carry low", W'(carry_o), W'(0));
    drive(1'b0, 8'hFE, 1'b0, 1'b1);
    tick("R6 not all ones");
  endtask

  task automatic t_cascade;
    drive(1'b0, 8'h0F, 1'b0, 1'b0);
    tick("R9 preset 0F");
    drive(1'b1, 8'h00, 1'b1, 1'b1);
    tick("R9 cross stage");
    chk("R9 value 10", q_o, 8'h10);
    drive(1'b0, 8'h2E, 1'b0, 1'b0);
    tick("R9 preset 2E");
    drive(1'b1, 8'h00, 1'b1, 1'b1);
    tick("R9 upper held");
    chk("R9 value 2F", q_o, 8'h2F);
    tick("R9 upper steps");
    chk("R9 value 30", q_o, 8'h30);
    drive(1'b0, 8'hFF, 1'b0, 1'b0);
    tick("R5 preset FF");
    drive(1'b1, 8'h00, 1'b1, 1'b1);
    tick("R5 full wrap");
    chk("R5 value 00", q_o, 8'h00);
  endtask

  task automatic t_midcycle;
    drive(1'b0, 8'h55, 1'b0, 1'b0);
    tick("R7 preset");
    drive(1'b1, 8'h00, 1'b0, 1'b0);
    #2 load_ni = 1'b0; data_i = 8'hAA; en_p_i = 1'b1; en_t_i = 1'b1;
    #3 load_ni = 1'b1; en_p_i = 1'b0; en_t_i = 1'b0;
    #1;
    chk("R7 no change between edges", q_o, 8'h55);
    chk("R1 no change without edge", q_o, exp_q);
    tick("R7 edge sees hold");
  endtask

  task automatic t_async_clear;
    drive(1'b0, 8'h9C, 1'b0, 1'b0);
    tick("R2 preset");
    drive(1'b0, 8'h77, 1'b1, 1'b1);
    #4 rst_ni = 1'b0; #1;
    exp_q = '0;
    chk_all("R2 async clear mid-cycle");
    tick("R2 clear beats load");
    @(negedge clk_i); #5 rst_ni = 1'b1;
    load_ni = 1'b1; en_p_i = 1'b0;
    tick("R2 released");
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_load_collide();
    t_enables();
    t_carry();
    t_cascade();
    t_midcycle();
    t_async_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule